// File: doc/BRIEF.md
# Multi-Pair PWM Controller with Trip

This block produces four pairs of pulse-width-modulated outputs, eight pins in all. Each pair owns a 16-bit up-counter that advances on a shared PWM tick and wraps after a programmable length. A high-side and a low-side pin are steered by three compare values and by the length. A common prescaler derives the tick from the system clock by a power-of-two divide between 2 and 256.

Configuration arrives over a simple one-cycle write strobe with a 5-bit address. Timing values are written into staging registers and copied into the working set only when the counter wraps, or at any time while the pair is halted, so a change in mid-period never cuts a pulse short. An active-low trip input acts as an emergency stop. Its falling edge latches a sticky fault. The fault drives every high-side pin high and every low-side pin low, and it raises an interrupt line that software can mask. Software releases the fault only while the trip input is back high. A mode bit for pairs 0 and 1 is kept and exposed, with H-bridge as the reset value. Pairs 2 and 3 report standard mode permanently.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: After reset, every high-side pin is 1, every low-side pin is 0, the interrupt line is 0, the mode outputs of pairs 0 and 1 are 1 and those of pairs 2 and 3 are 0.
- R2: Address 0 is control: bit 0 run, bits 3:1 divider select, bit 4 interrupt enable, bits 6:5 mode of pairs 1:0, bit 7 write-one trip release (not stored). Pair p uses addresses 8+4p+k: k=0 length L, k=1 compare A, k=2 compare B, k=3 compare C. While running, each pair counter steps 0,1,...,L on successive PWM ticks and returns to 0 on the tick after L.
- R3: With divider select s, a PWM tick occurs once every 2^(s+1) clocks, starting 2^(s+1) clocks after the counters are released.
- R4: On the clock after the counter holds A the high side becomes 1; on the clock after it holds B the high side becomes 0; B wins when A equals B.
- R5: On the clock after the counter holds L the low side becomes 1. On the clock after it holds C, or holds B while the high side is 1, the low side becomes 0. Clearing wins over setting.
- R6: Length and compare writes to a running pair take effect only when its counter wraps. While a pair is halted they take effect on the next clock.
- R7: While run is 0 or a trip is latched, all counters and the prescaler hold at 0 and all pins are at off level (high side 1, low side 0) from the following clock.
- R8: A 1-to-0 transition of the trip input latches the trip and forces all pins off at the clock edge that first samples the low level.
- R9: The latched trip persists until bit 7 of a control write is 1 while the trip input is 1. Such a write with the trip input at 0 is ignored.
- R10: The interrupt line equals latched trip AND interrupt enable. Masking it does not clear the latched trip.
- R11: The mode outputs of pairs 0 and 1 follow control bits 5 and 6. Those of pairs 2 and 3 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| trip_n | input | 1 | Active-low fault input, falling edge trips |
| pwm_hi | output | 4 | High-side outputs, one per pair |
| pwm_lo | output | 4 | Low-side outputs, one per pair |
| trip_irq | output | 1 | Masked trip interrupt |
| hb_mode | output | 4 | Per-pair H-bridge mode indication |

## Verification
On every cycle, the assertions check these properties:
- A counter never exceeds its working length.
- The working set stays frozen between wraps.
- Ticks are never adjacent.
- A falling trip edge always latches a fault.
- A latched fault cannot be released while the input is low.
- Halt or trip leaves the pins at off level.

Only the bench scenarios show the full waveforms across several divider settings:
- Where each edge lands against the four compare patterns, including equal and coinciding compares.
- That a mid-period rewrite changes nothing until the wrap.
- The release and masking sequence around a trip.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int CW        = 16;
  localparam int PAIR_BASE = 8;

  typedef struct packed {
    logic [CW-1:0] len;
    logic [CW-1:0] ca;
    logic [CW-1:0] cb;
    logic [CW-1:0] cc;
  } pair_cfg_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(2) << sel) - DIV_W'(1);
  assign tick  = go && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !go)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  // R3: the smallest divide is two, so ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pwm_pair_core.sv
module pwm_pair_core
  import pwm_trip_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go,
  input  logic      tick,
  input  pair_cfg_t cfg_in,
  output logic      hi_o,
  output logic      lo_o
);
  pair_cfg_t     act_q;
  logic [CW-1:0] cnt_q;
  logic          hi_q, lo_q;
  logic          at_len, hit_a, hit_b, hit_c;

  assign at_len = (cnt_q == act_q.len);
  assign hit_a  = (cnt_q == act_q.ca);
  assign hit_b  = (cnt_q == act_q.cb);
  assign hit_c  = (cnt_q == act_q.cc);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      hi_q  <= 1'b1;
      lo_q  <= 1'b0;
    end else if (!go) begin
      act_q <= cfg_in;
      cnt_q <= '0;
      hi_q  <= 1'b1;
      lo_q  <= 1'b0;
    end else begin
      if (tick) begin
        if (at_len) begin
          cnt_q <= '0;
          act_q <= cfg_in;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (hit_b)      hi_q <= 1'b0;
      else if (hit_a) hi_q <= 1'b1;
      if (hit_c || (hi_q && hit_b)) lo_q <= 1'b0;
      else if (at_len)              lo_q <= 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R2: the counter stays inside the working period
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_q.len);
  // R6: working values change only at a wrap or while halted
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (go && !(tick && at_len)) |=> $stable(act_q));
  // R4: compare B turns the high side off
  a_r4_hi_falls: assert property (@(posedge clk) disable iff (rst)
    (go && hit_b) |=> !hi_q);
  // R5: compare C turns the low side off
  a_r5_lo_falls: assert property (@(posedge clk) disable iff (rst)
    (go && hit_c) |=> !lo_q);
  // R7: a halted pair sits at zero with off levels
  a_r7_halt_off: assert property (@(posedge clk) disable iff (rst)
    !go |=> (hi_q && !lo_q && cnt_q == '0));
endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic trip_n,
  input  logic clr,
  output logic tripped,
  output logic fall
);
  logic prev_q, trip_q;

  assign fall    = prev_q && !trip_n;
  assign tripped = trip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      trip_q <= 1'b0;
    end else begin
      prev_q <= trip_n;
      if (fall)               trip_q <= 1'b1;
      else if (clr && trip_n) trip_q <= 1'b0;
    end
  end

  // R8: a falling trip edge always latches
  a_r8_fall_latches: assert property (@(posedge clk) disable iff (rst)
    fall |=> trip_q);
  // R9: a release while the input is low does nothing
  a_r9_no_release_low: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !trip_n) |=> trip_q);
  // R9: without a release the fault is held
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !clr) |=> trip_q);
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NPAIRS   = 4,
  parameter int HB_PAIRS = 2,
  parameter int AW       = 5,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              trip_n,
  output logic [NPAIRS-1:0] pwm_hi,
  output logic [NPAIRS-1:0] pwm_lo,
  output logic              trip_irq,
  output logic [NPAIRS-1:0] hb_mode
);
  localparam int B_RUN  = 0;
  localparam int B_SEL  = 1;
  localparam int B_IEN  = B_SEL + SEL_W;
  localparam int B_MODE = B_IEN + 1;
  localparam int B_CLR  = B_MODE + HB_PAIRS;

  logic                run_q, ien_q;
  logic [SEL_W-1:0]    sel_q;
  logic [HB_PAIRS-1:0] mode_q;
  logic                ctrl_wr, clr, tripped, fall, go, tick;

  assign ctrl_wr = wr_en && (wr_addr == '0);
  assign clr     = ctrl_wr && wr_data[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      sel_q  <= '0;
      mode_q <= '1;
    end else if (ctrl_wr) begin
      run_q  <= wr_data[B_RUN];
      ien_q  <= wr_data[B_IEN];
      sel_q  <= wr_data[B_SEL +: SEL_W];
      mode_q <= wr_data[B_MODE +: HB_PAIRS];
    end
  end

  pwm_trip_latch u_trip (
    .clk(clk), .rst(rst), .trip_n(trip_n), .clr(clr),
    .tripped(tripped), .fall(fall)
  );

  assign go       = run_q && !tripped && !fall;
  assign trip_irq = tripped && ien_q;

  pwm_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst(rst), .go(go), .sel(sel_q), .tick(tick)
  );

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam logic [AW-1:0] BASE = AW'(PAIR_BASE + 4 * p);
    pair_cfg_t stg_q;
    logic      hit;

    assign hit = wr_en && (wr_addr[AW-1:2] == BASE[AW-1:2]);

    always_ff @(posedge clk) begin
      if (rst) stg_q <= '0;
      else if (hit) begin
        case (wr_addr[1:0])
          2'd0:    stg_q.len <= wr_data;
          2'd1:    stg_q.ca  <= wr_data;
          2'd2:    stg_q.cb  <= wr_data;
          default: stg_q.cc  <= wr_data;
        endcase
      end
    end

    pwm_pair_core u_core (
      .clk(clk), .rst(rst), .go(go), .tick(tick), .cfg_in(stg_q),
      .hi_o(pwm_hi[p]), .lo_o(pwm_lo[p])
    );

    if (p < HB_PAIRS) begin : g_hb
      assign hb_mode[p] = mode_q[p];
    end else begin : g_std
      assign hb_mode[p] = 1'b0;
    end
  end

  // R8: a latched fault always shows at the pins
  a_r8_trip_off: assert property (@(posedge clk) disable iff (rst)
    tripped |-> (&pwm_hi && !(|pwm_lo)));
  // R7: clearing run puts every pin at off level
  a_r7_run_off: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (&pwm_hi && !(|pwm_lo)));
  // R10: the interrupt line never rises without a latched fault
  a_r10_irq_needs_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_irq) |-> tripped);
endmodule

// File: tb/sim_pwm_trip_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_trip_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip_n = 1'b1;
  logic [3:0]  pwm_hi, pwm_lo, hb_mode;
  logic        trip_irq;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pwm_trip_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip_n(trip_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .trip_irq(trip_irq),
    .hb_mode(hb_mode)
  );

  typedef struct {
    logic [3:0] hi, lo, mode;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state, built from the requirements
  logic        m_run, m_ien, m_trip, m_prev;
  logic [2:0]  m_sel;
  logic [1:0]  m_mode;
  int          m_div;
  logic [15:0] s_len[4], s_a[4], s_b[4], s_c[4];
  logic [15:0] a_len[4], a_a[4], a_b[4], a_c[4];
  logic [15:0] m_cnt[4];
  logic        m_hi[4], m_lo[4];

  always @(posedge clk) begin : model
    logic fall, go, tick, at, ha, hb, hc, oh;
    int   lim, p, f;
    exp_t e;
    if (rst) begin
      m_run = 0; m_ien = 0; m_trip = 0; m_prev = 1; m_sel = 0; m_mode = 2'b11; m_div = 0;
      for (int i = 0; i < 4; i++) begin
        s_len[i] = 0; s_a[i] = 0; s_b[i] = 0; s_c[i] = 0;
        a_len[i] = 0; a_a[i] = 0; a_b[i] = 0; a_c[i] = 0;
        m_cnt[i] = 0; m_hi[i] = 1; m_lo[i] = 0;
      end
    end else begin
      fall = m_prev && !trip_n;
      go   = m_run && !m_trip && !fall;
      lim  = (2 << m_sel) - 1;
      tick = go && (m_div >= lim);
      m_div = (!go || tick) ? 0 : m_div + 1;
      for (int i = 0; i < 4; i++) begin
        if (!go) begin
          a_len[i] = s_len[i]; a_a[i] = s_a[i]; a_b[i] = s_b[i]; a_c[i] = s_c[i];
          m_cnt[i] = 0; m_hi[i] = 1; m_lo[i] = 0;
        end else begin
          at = m_cnt[i] == a_len[i]; ha = m_cnt[i] == a_a[i];
          hb = m_cnt[i] == a_b[i];   hc = m_cnt[i] == a_c[i];
          oh = m_hi[i];
          if (hb) m_hi[i] = 0; else if (ha) m_hi[i] = 1;
          if (hc || (oh && hb)) m_lo[i] = 0; else if (at) m_lo[i] = 1;
          if (tick) begin
            if (at) begin
              m_cnt[i] = 0;
              a_len[i] = s_len[i]; a_a[i] = s_a[i]; a_b[i] = s_b[i]; a_c[i] = s_c[i];
            end else m_cnt[i] = m_cnt[i] + 1;
          end
        end
      end
      if (fall) m_trip = 1;
      else if (wr_en && wr_addr == 0 && wr_data[7] && trip_n) m_trip = 0;
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_run = wr_data[0]; m_sel = wr_data[3:1]; m_ien = wr_data[4]; m_mode = wr_data[6:5];
        end else if (wr_addr >= 8 && wr_addr < 24) begin
          p = (wr_addr - 8) / 4; f = (wr_addr - 8) % 4;
          case (f)
            0: s_len[p] = wr_data;
            1: s_a[p]   = wr_data;
            2: s_b[p]   = wr_data;
            default: s_c[p] = wr_data;
          endcase
        end
      end
      m_prev = trip_n;
    end
    for (int i = 0; i < 4; i++) begin
      e.hi[i] = m_hi[i]; e.lo[i] = m_lo[i];
    end
    e.mode = {2'b00, m_mode};
    e.irq  = m_trip && m_ien;
    e.tag  = tag;
    sb.push_back(e);
  end

  always @(negedge clk) begin : monitor
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_vec++;
      if (pwm_hi !== e.hi || pwm_lo !== e.lo || hb_mode !== e.mode || trip_irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: hi=%b lo=%b mode=%b irq=%b expected hi=%b lo=%b mode=%b irq=%b",
                 e.tag, pwm_hi, pwm_lo, hb_mode, trip_irq, e.hi, e.lo, e.mode, e.irq);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pair_cfg(input int p, input int l, input int ca, input int cb, input int cc);
    wr(5'(8 + 4 * p), 16'(l));
    wr(5'(9 + 4 * p), 16'(ca));
    wr(5'(10 + 4 * p), 16'(cb));
    wr(5'(11 + 4 * p), 16'(cc));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    tag = "R1 reset";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R6: writes while halted load right away
    tag = "R6 halted load";
    pair_cfg(0, 9, 2, 6, 8);
    pair_cfg(1, 5, 1, 3, 4);
    pair_cfg(2, 7, 3, 3, 7);
    pair_cfg(3, 4, 0, 4, 2);
    tag = "R2 R4 R5 div2";
    wr(0, 16'h0071);
    idle(80);
    tag = "R3 R4 R5 div8";
    wr(0, 16'h0075);
    idle(200);
    tag = "R6 rewrite mid-period";
    wr(8, 16'd12);
    wr(9, 16'd5);
    idle(220);
    tag = "R3 div4";
    wr(0, 16'h0073);
    idle(60);
    tag = "R8 trip edge";
    trip_n = 1'b0;
    idle(10);
    tag = "R9 release while low";
    wr(0, 16'h00F3);
    idle(5);
    trip_n = 1'b1;
    idle(5);
    tag = "R10 mask";
    wr(0, 16'h0063);
    idle(5);
    tag = "R9 release";
    wr(0, 16'h00E3);
    idle(80);
    tag = "R10 trip masked";
    trip_n = 1'b0;
    idle(4);
    trip_n = 1'b1;
    idle(4);
    wr(0, 16'h0073);
    idle(4);
    tag = "R9 R10 release";
    wr(0, 16'h00F3);
    idle(40);
    tag = "R7 R11 stop";
    wr(0, 16'h0044);
    idle(30);
    tag = "R11 mode";
    wr(0, 16'h0021);
    idle(30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule